// File: doc/BRIEF.md
# Two-Stage Latched Interrupt Aggregator

This block collects up to seventeen serial-interrupt level lines, a bus-reset event, six transfer-error events and two bus-master request lines, and folds them into one interrupt output. It does so through two cascaded stages. Each stage holds a sticky status word that software clears by writing ones. The first stage, the host-controller stage, is gated by an enable bit and a mask. Its aggregate feeds bit 11 of the second stage's read-only raw-input word. The second stage, the bus-master stage, latches its raw input through its own mask and drives the interrupt pin.

Software reaches both stages through a 32-bit register port. Writes take one cycle and reads are combinational. Both stages are re-evaluated on every clock, so the interrupt output reflects a mask, control or clear write one cycle after that write. The first stage also keeps a few configuration words that are stored and read back but act on nothing here: segment select, firmware read size, quiet mode and start-frame length. The same holds for the second stage's polarity word.

Top module: `irq_cascade_agg`

## Requirements
- R1: After reset, every status, mask, control, polarity, segment and error-address word reads 0. The firmware read-size word (offset 0x28) reads 0x02000000, the 4-byte code. `irq_out` is 0.
- R2: A high level on serial input n sets first-stage status bit 31−n (offset 0x38) at the next clock edge. The bus-reset event sets bit 10, error event k sets bit 2+k, and bus-master request k sets bit k. Bits 14:11 and 9:8 never set.
- R3: A first-stage status bit stays set after its input falls, until a write to 0x38 with a one in that bit. If the input is still high in the cycle of the clear write, the bit stays set.
- R4: The first-stage aggregate is high only when control bit 31 (offset 0x30) is set and status AND mask (offset 0x34) is non-zero. It is visible at bit 11 of the raw-input word (offset 0x5C).
- R5: Second-stage status (offset 0x50) ORs in raw-input AND second-stage mask (offset 0x54) on every clock. Writing ones to 0x50 clears those bits, except where the masked raw input is still high in that cycle.
- R6: `irq_out` is high exactly when second-stage status is non-zero.
- R7: Writes to the raw-input word have no effect. The polarity word (offset 0x58) is stored and read back, and has no effect on latching or on `irq_out`.
- R8: Reads of an unimplemented offset return 0xFFFFFFFF, and writes to such offsets change no register. Writes to the error-address word (offset 0x40) are ignored.
- R9: The segment select (0x24), firmware read size (0x28) and control word (0x30) read back what was written. In the control word, bit 30 is quiet mode and bits 25:24 are the start-frame code (0, 1, 2 for 4, 6, 8 clocks).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| serirq_lvl | input | NUM_SER (17) | Serial-interrupt level lines, line n maps to status bit 31−n |
| lreset_evt | input | 1 | Bus-reset event level |
| xfer_err_evt | input | 6 | Transfer and turnaround error event levels |
| bm_req_evt | input | 2 | Bus-master request levels |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (8) | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_out | output | 1 | Aggregated interrupt |

## Verification
The assertions assume that event inputs and register accesses are synchronous to `clk` and settle before each rising edge. They also assume that `reg_addr` and `reg_wdata` are valid whenever `reg_we` is high. The stimulus changes every input one nanosecond after a rising edge and holds it for whole cycles. It drives a write strobe for one cycle at a time only. Inputs stay at zero while reset is held, so no event is lost in the first cycle after release.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int DATA_W = 32;

  localparam logic [7:0] OFF_SEGSEL = 8'h24;
  localparam logic [7:0] OFF_RDSIZE = 8'h28;
  localparam logic [7:0] OFF_CTRL   = 8'h30;
  localparam logic [7:0] OFF_MASK1  = 8'h34;
  localparam logic [7:0] OFF_STAT1  = 8'h38;
  localparam logic [7:0] OFF_ERRADR = 8'h40;
  localparam logic [7:0] OFF_STAT2  = 8'h50;
  localparam logic [7:0] OFF_MASK2  = 8'h54;
  localparam logic [7:0] OFF_POL2   = 8'h58;
  localparam logic [7:0] OFF_RAW2   = 8'h5C;

  localparam logic [DATA_W-1:0] RDSIZE_RST = 32'h0200_0000;
  localparam logic [DATA_W-1:0] UNMAPPED   = '1;
  localparam int               CTRL_EN_BIT = 31;
  localparam int               CASCADE_BIT = 11;
  localparam int               SER_SLOTS   = 17;
  localparam int               ERR_EVTS    = 6;
  localparam int               BM_EVTS     = 2;

  typedef struct packed {
    logic segsel;
    logic rdsize;
    logic ctrl;
    logic mask1;
    logic stat1;
    logic stat2;
    logic mask2;
    logic pol2;
  } wr_sel_t;
endpackage

// File: rtl/irqagg_evt_map.sv
module irqagg_evt_map
  import irqagg_pkg::*;
#(
  parameter int NUM_SER = 17
) (
  input  logic [NUM_SER-1:0]  serirq_lvl,
  input  logic                lreset_evt,
  input  logic [ERR_EVTS-1:0] xfer_err_evt,
  input  logic [BM_EVTS-1:0]  bm_req_evt,
  output logic [DATA_W-1:0]   set_vec
);
  logic [SER_SLOTS-1:0] ser_bits;

  // line n lands on the slot at the top minus n
  for (genvar n = 0; n < SER_SLOTS; n++) begin : g_slot
    if (n < NUM_SER) begin : g_used
      assign ser_bits[SER_SLOTS-1-n] = serirq_lvl[n];
    end else begin : g_empty
      assign ser_bits[SER_SLOTS-1-n] = 1'b0;
    end
  end

  assign set_vec = {ser_bits, 4'b0000, lreset_evt, 2'b00, xfer_err_evt, bm_req_evt};
endmodule

// File: rtl/irqagg_hc_stage.sv
module irqagg_hc_stage
  import irqagg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_segsel,
  input  logic              we_rdsize,
  input  logic              we_ctrl,
  input  logic              we_mask,
  input  logic              we_stat,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] set_vec,
  output logic [DATA_W-1:0] segsel_q,
  output logic [DATA_W-1:0] rdsize_q,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] mask_q,
  output logic [DATA_W-1:0] stat_q,
  output logic              hc_irq
);
  logic [DATA_W-1:0] segsel_d, rdsize_d, ctrl_d, mask_d, stat_d, clr_v;

  always_comb begin
    segsel_d = segsel_q;
    rdsize_d = rdsize_q;
    ctrl_d   = ctrl_q;
    mask_d   = mask_q;
    if (we_segsel) segsel_d = wdata;
    if (we_rdsize) rdsize_d = wdata;
    if (we_ctrl)   ctrl_d   = wdata;
    if (we_mask)   mask_d   = wdata;
    clr_v  = we_stat ? wdata : '0;
    // new levels are ORed in after the clear, so a same-cycle set survives
    stat_d = (stat_q & ~clr_v) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      segsel_q <= '0;
      rdsize_q <= RDSIZE_RST;
      ctrl_q   <= '0;
      mask_q   <= '0;
      stat_q   <= '0;
    end else begin
      segsel_q <= segsel_d;
      rdsize_q <= rdsize_d;
      ctrl_q   <= ctrl_d;
      mask_q   <= mask_d;
      stat_q   <= stat_d;
    end
  end

  assign hc_irq = ctrl_q[CTRL_EN_BIT] && ((stat_q & mask_q) != '0);

  logic armed_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  p_level_sets_r2: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    1'b1 |=> ((stat_q & $past(set_vec)) == $past(set_vec)));

  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    1'b1 |=> ((stat_q & $past(stat_q & ~clr_v)) == $past(stat_q & ~clr_v)));

  p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    we_stat |=> ((stat_q & $past(wdata & ~set_vec)) == '0));
endmodule

// File: rtl/irqagg_master_stage.sv
module irqagg_master_stage
  import irqagg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_stat,
  input  logic              we_mask,
  input  logic              we_pol,
  input  logic [DATA_W-1:0] wdata,
  input  logic              hc_irq,
  output logic [DATA_W-1:0] raw_vec,
  output logic [DATA_W-1:0] stat_q,
  output logic [DATA_W-1:0] mask_q,
  output logic [DATA_W-1:0] pol_q,
  output logic              irq
);
  logic [DATA_W-1:0] stat_d, mask_d, pol_d, clr_v, hit_v;

  always_comb begin
    raw_vec = '0;
    raw_vec[CASCADE_BIT] = hc_irq;
  end

  always_comb begin
    mask_d = mask_q;
    pol_d  = pol_q;
    if (we_mask) mask_d = wdata;
    if (we_pol)  pol_d  = wdata;
    clr_v  = we_stat ? wdata : '0;
    hit_v  = raw_vec & mask_q;
    stat_d = (stat_q & ~clr_v) | hit_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
      pol_q  <= '0;
    end else begin
      stat_q <= stat_d;
      mask_q <= mask_d;
      pol_q  <= pol_d;
    end
  end

  assign irq = (stat_q != '0);

  logic armed_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  p_latch_r5: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    1'b1 |=> ((stat_q & $past(hit_v)) == $past(hit_v)));

  p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    we_stat |=> ((stat_q & $past(wdata & ~hit_v)) == '0));
endmodule

// File: rtl/irq_cascade_agg.sv
module irq_cascade_agg
  import irqagg_pkg::*;
#(
  parameter int NUM_SER = 17,
  parameter int ADDR_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SER-1:0]  serirq_lvl,
  input  logic                lreset_evt,
  input  logic [ERR_EVTS-1:0] xfer_err_evt,
  input  logic [BM_EVTS-1:0]  bm_req_evt,
  input  logic                reg_we,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic                irq_out
);
  localparam logic [ADDR_W-1:0] A_SEG  = ADDR_W'(OFF_SEGSEL);
  localparam logic [ADDR_W-1:0] A_RDSZ = ADDR_W'(OFF_RDSIZE);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_MSK1 = ADDR_W'(OFF_MASK1);
  localparam logic [ADDR_W-1:0] A_STA1 = ADDR_W'(OFF_STAT1);
  localparam logic [ADDR_W-1:0] A_ERRA = ADDR_W'(OFF_ERRADR);
  localparam logic [ADDR_W-1:0] A_STA2 = ADDR_W'(OFF_STAT2);
  localparam logic [ADDR_W-1:0] A_MSK2 = ADDR_W'(OFF_MASK2);
  localparam logic [ADDR_W-1:0] A_POL2 = ADDR_W'(OFF_POL2);
  localparam logic [ADDR_W-1:0] A_RAW2 = ADDR_W'(OFF_RAW2);

  logic [DATA_W-1:0] set_vec;
  logic [DATA_W-1:0] segsel_q, rdsize_q, ctrl_q, mask1_q, stat1_q;
  logic [DATA_W-1:0] raw2, stat2_q, mask2_q, pol2_q;
  logic              hc_irq;
  wr_sel_t           wsel;

  // write decode; raw input and error address take no write
  always_comb begin
    wsel = '0;
    if (reg_we) begin
      case (reg_addr)
        A_SEG:   wsel.segsel = 1'b1;
        A_RDSZ:  wsel.rdsize = 1'b1;
        A_CTRL:  wsel.ctrl   = 1'b1;
        A_MSK1:  wsel.mask1  = 1'b1;
        A_STA1:  wsel.stat1  = 1'b1;
        A_STA2:  wsel.stat2  = 1'b1;
        A_MSK2:  wsel.mask2  = 1'b1;
        A_POL2:  wsel.pol2   = 1'b1;
        default: wsel = '0;
      endcase
    end
  end

  irqagg_evt_map #(.NUM_SER(NUM_SER)) u_map (
    .serirq_lvl   (serirq_lvl),
    .lreset_evt   (lreset_evt),
    .xfer_err_evt (xfer_err_evt),
    .bm_req_evt   (bm_req_evt),
    .set_vec      (set_vec)
  );

  irqagg_hc_stage u_hc (
    .clk       (clk),
    .rst_n     (rst_n),
    .we_segsel (wsel.segsel),
    .we_rdsize (wsel.rdsize),
    .we_ctrl   (wsel.ctrl),
    .we_mask   (wsel.mask1),
    .we_stat   (wsel.stat1),
    .wdata     (reg_wdata),
    .set_vec   (set_vec),
    .segsel_q  (segsel_q),
    .rdsize_q  (rdsize_q),
    .ctrl_q    (ctrl_q),
    .mask_q    (mask1_q),
    .stat_q    (stat1_q),
    .hc_irq    (hc_irq)
  );

  irqagg_master_stage u_bm (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_stat (wsel.stat2),
    .we_mask (wsel.mask2),
    .we_pol  (wsel.pol2),
    .wdata   (reg_wdata),
    .hc_irq  (hc_irq),
    .raw_vec (raw2),
    .stat_q  (stat2_q),
    .mask_q  (mask2_q),
    .pol_q   (pol2_q),
    .irq     (irq_out)
  );

  always_comb begin
    case (reg_addr)
      A_SEG:   reg_rdata = segsel_q;
      A_RDSZ:  reg_rdata = rdsize_q;
      A_CTRL:  reg_rdata = ctrl_q;
      A_MSK1:  reg_rdata = mask1_q;
      A_STA1:  reg_rdata = stat1_q;
      A_ERRA:  reg_rdata = '0;
      A_STA2:  reg_rdata = stat2_q;
      A_MSK2:  reg_rdata = mask2_q;
      A_POL2:  reg_rdata = pol2_q;
      A_RAW2:  reg_rdata = raw2;
      default: reg_rdata = UNMAPPED;
    endcase
  end

  p_onehot_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wsel));
endmodule

// File: tb/sim_irq_cascade_agg.sv
module sim_irq_cascade_agg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [16:0] serirq_lvl = '0;
  logic        lreset_evt = 1'b0;
  logic [5:0]  xfer_err_evt = '0;
  logic [1:0]  bm_req_evt = '0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  always #5 clk = ~clk;

  irq_cascade_agg u0 (
    .clk(clk), .rst_n(rst_n), .serirq_lvl(serirq_lvl), .lreset_evt(lreset_evt),
    .xfer_err_evt(xfer_err_evt), .bm_req_evt(bm_req_evt), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  // monitor: compares one queued expectation per falling edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb.pop_front();
      act = it.is_irq ? {31'b0, irq_out} : reg_rdata;
      n_chk++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic chk_reg(input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(posedge clk); #1;
    reg_addr = a;
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    sb.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    item_t it;
    @(posedge clk); #1;
    it.is_irq = 1'b1; it.exp = {31'b0, e}; it.tag = tag;
    sb.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic pulse_ser(input int n);
    @(posedge clk); #1;
    serirq_lvl[n] = 1'b1;
    @(posedge clk); #1;
    serirq_lvl[n] = 1'b0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    chk_reg(8'h38, 32'h0, "R1 stat1");
    chk_reg(8'h34, 32'h0, "R1 mask1");
    chk_reg(8'h30, 32'h0, "R1 ctrl");
    chk_reg(8'h28, 32'h0200_0000, "R1 rdsize");
    chk_reg(8'h50, 32'h0, "R1 stat2");
    chk_reg(8'h5C, 32'h0, "R1 raw");
    chk_irq(1'b0, "R1 irq");

    // R2 mapping of each source class
    pulse_ser(0);
    chk_reg(8'h38, 32'h8000_0000, "R2 ser0 to bit31");
    pulse_ser(16);
    @(posedge clk); #1 lreset_evt = 1'b1; xfer_err_evt[0] = 1'b1; bm_req_evt[1] = 1'b1;
    @(posedge clk); #1 lreset_evt = 1'b0; xfer_err_evt = '0; bm_req_evt = '0;
    // R3 levels gone, bits remain
    chk_reg(8'h38, 32'h8000_8406, "R2 R3 mapped and sticky");
    chk_reg(8'h5C, 32'h0, "R4 disabled raw");

    // R4 gating by mask and enable
    wr(8'h34, 32'h8000_0000);
    chk_reg(8'h5C, 32'h0, "R4 enable off");
    wr(8'h30, 32'hC100_0000);
    chk_reg(8'h30, 32'hC100_0000, "R9 ctrl quiet 6clk");
    chk_reg(8'h5C, 32'h0000_0800, "R4 cascade bit");
    chk_reg(8'h50, 32'h0, "R5 mask2 zero");
    chk_irq(1'b0, "R6 irq low");

    // R7 polarity and raw input inert
    wr(8'h58, 32'hFFFF_FFFF);
    chk_reg(8'h58, 32'hFFFF_FFFF, "R7 pol readback");
    chk_irq(1'b0, "R7 pol no effect");
    wr(8'h5C, 32'h0);
    chk_reg(8'h5C, 32'h0000_0800, "R7 raw read-only");

    // R5 R6 second-stage latch and clear
    wr(8'h54, 32'h0000_0800);
    chk_reg(8'h50, 32'h0000_0800, "R5 latched");
    chk_irq(1'b1, "R6 irq high");
    wr(8'h50, 32'h0000_0800);
    chk_reg(8'h50, 32'h0000_0800, "R5 set wins");
    wr(8'h38, 32'h8000_0000);
    chk_reg(8'h38, 32'h0000_8406, "R3 w1c stage1");
    chk_reg(8'h5C, 32'h0, "R4 cascade drops");
    chk_reg(8'h50, 32'h0000_0800, "R5 stays sticky");
    wr(8'h50, 32'h0000_0800);
    chk_reg(8'h50, 32'h0, "R5 cleared");
    chk_irq(1'b0, "R6 irq low after clear");

    // R3 set beats clear
    @(posedge clk); #1 serirq_lvl[3] = 1'b1;
    wr(8'h38, 32'h1000_0000);
    chk_reg(8'h38, 32'h1000_8406, "R3 set wins");
    @(posedge clk); #1 serirq_lvl[3] = 1'b0;
    wr(8'h38, 32'h1000_0000);
    chk_reg(8'h38, 32'h0000_8406, "R3 cleared after release");

    // R8 unmapped and error address
    chk_reg(8'h00, 32'hFFFF_FFFF, "R8 unmapped 0x00");
    chk_reg(8'h60, 32'hFFFF_FFFF, "R8 unmapped 0x60");
    wr(8'h40, 32'h0000_1234);
    chk_reg(8'h40, 32'h0, "R8 erraddr ignored");
    wr(8'h3C, 32'h0000_0000);
    chk_reg(8'h34, 32'h8000_0000, "R8 unmapped write harmless");
    chk_reg(8'h3C, 32'hFFFF_FFFF, "R8 unmapped stays");

    // R9 configuration words
    wr(8'h24, 32'h0000_0005);
    chk_reg(8'h24, 32'h0000_0005, "R9 segsel");
    wr(8'h28, 32'h0700_0000);
    chk_reg(8'h28, 32'h0700_0000, "R9 rdsize 128B");

    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule